// File: doc/BRIEF.md
# DRAM strobe cycle classifier

This block watches the control strobes of a 16-bit extended-data-out DRAM port from the device side. It samples the row strobe, the column strobe, the lower and upper byte write enables, the output enable and the multiplexed address on a fast system clock. From those samples it works out what kind of access the controller performed. The pins are brought through a synchronizer before any decision is made. The type of each access is then taken from two things: the order in which the strobe edges arrive, and the pin levels while the column strobe is low.

Each finished access produces a report that is one clock wide. The report carries a class code, a write-mode code, an error flag, a direction code for each byte lane, the row address and the column address. A column access is reported when its column strobe rises. It is reported earlier if the row strobe rises while the column strobe is still low. A row period that ends with no column access is reported as a refresh when the row strobe rises. The block is meant as a protocol checker in benches or as a bus analyzer. It does not hold any storage array, and it makes no analog timing checks.

Top module: `dram_cycle_monitor`

## Requirements
- R1: While reset is held and in the first cycle after it is released, rpt_valid is 0 and every report field is 0.
- R2: A report goes high on the third rising clock edge after the first edge that samples the strobe change ending the access. It stays high for exactly one cycle.
- R3: A column access in which no write enable is sampled low is reported with class 1 (word read), write mode 0 and error 0. Both lane codes are 1 (driving out) if the output enable was sampled low at any time while the column strobe was low, and 0 (high impedance) otherwise.
- R4: If a write enable is sampled low in the same sample as the column-strobe fall, or earlier, the access is an early write with write mode 1. The class is 2 for the lower lane only (lwe_n), 3 for the upper lane only (uwe_n) and 4 for both. Each written lane has code 2 (data in) and each unwritten lane has code 0.
- R5: A write enable that falls k samples after the column strobe falls, with k at least RMW_CAS_MIN (default 4), and at least RMW_RAS_MIN (default 8) samples after the row strobe falls, gives a read-modify-write. The report has write mode 2, code 3 (out then in) on each written lane, and code 1 or 0 on the other lane according to the output-enable rule of R3.
- R6: A write enable that falls after the column strobe but before either minimum delay of R5 is met sets rpt_err to 1 and write mode to 0. Each written lane has code 2.
- R7: rpt_row holds the address sampled when the row strobe falls. rpt_col holds the address sampled when the column strobe falls.
- R8: In page mode, every column-strobe pulse inside one row-low period gives its own report, with the shared row address and its own column address. No extra report follows when the row strobe rises.
- R9: A row-low period with no column-strobe fall is reported when the row strobe rises, with class 5, the latched row, column 0 and both lanes at 0.
- R10: If the column strobe is already low before the row strobe falls, the period is reported when the row strobe rises, with class 6 and all other fields 0. Column pulses inside that period give no report.
- R11: If the row strobe rises while a column access is still open, that access is reported then, and only once. This includes a column strobe that rises in the same sample.
- R12: Column-strobe pulses while the row strobe is high give no report. In every cycle without a report, all report fields read 0 (class 0 = standby, lanes high impedance).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, much faster than the strobes |
| rst | input | 1 | Synchronous active-high reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| lwe_n | input | 1 | Lower byte write enable, active low |
| uwe_n | input | 1 | Upper byte write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Multiplexed row/column address |
| rpt_valid | output | 1 | One-cycle report strobe |
| rpt_class | output | 3 | 0 standby, 1 read, 2 lower write, 3 upper write, 4 word write, 5 row-only refresh, 6 column-first refresh |
| rpt_wmode | output | 2 | 0 none, 1 early write, 2 read-modify-write |
| rpt_err | output | 1 | Write strobe fell outside both timing windows |
| rpt_lane_lo | output | 2 | Lower lane: 0 high-Z, 1 out, 2 in, 3 out then in |
| rpt_lane_hi | output | 2 | Upper lane, same coding |
| rpt_row | output | ADDR_W | Latched row address |
| rpt_col | output | ADDR_W | Latched column address |

## Verification
Several decisions can fall in the same sample. The close of a column access can coincide with the row-strobe rise that would otherwise produce a refresh report. The bench forces this by raising both strobes in one drive, and it also keeps the column strobe low across the row-strobe rise, as in a hidden refresh. It then checks that exactly one access report appears, followed only by the column-first refresh. The write-strobe fall is also set against the column-strobe fall in the same sample (early) and at a sweep of later delays. In each case the bench checks whether the early, read-modify-write or indeterminate outcome is chosen, using the arithmetic window rule.

// File: rtl/dcm_pkg.sv
package dcm_pkg;

  typedef enum logic [2:0] {
    CLS_STANDBY = 3'd0,
    CLS_READ    = 3'd1,
    CLS_WR_LO   = 3'd2,
    CLS_WR_HI   = 3'd3,
    CLS_WR_WORD = 3'd4,
    CLS_REF_ROW = 3'd5,
    CLS_REF_CBR = 3'd6
  } cyc_class_e;

  typedef enum logic [1:0] {
    WM_NONE  = 2'd0,
    WM_EARLY = 2'd1,
    WM_RMW   = 2'd2
  } wmode_e;

  localparam logic [1:0] LANE_HIZ    = 2'd0;
  localparam logic [1:0] LANE_OUT    = 2'd1;
  localparam logic [1:0] LANE_IN     = 2'd2;
  localparam logic [1:0] LANE_OUT_IN = 2'd3;

  typedef struct packed {
    cyc_class_e cls;
    wmode_e     wm;
    logic       err;
    logic [1:0] lo;
    logic [1:0] hi;
  } acc_info_t;

endpackage

// File: rtl/dcm_sync.sv
module dcm_sync #(
  parameter int             W       = 8,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/dcm_access.sv
module dcm_access
  import dcm_pkg::*;
#(
  parameter int CNT_W       = 6,
  parameter int RMW_CAS_MIN = 4,
  parameter int RMW_RAS_MIN = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             finish,
  input  logic [1:0]       we_n,
  input  logic [1:0]       we_fall,
  input  logic             oe_n,
  input  logic [CNT_W-1:0] ras_cnt,
  output logic             act,
  output acc_info_t        info
);

  localparam logic [CNT_W-1:0] CAS_MIN = CNT_W'(RMW_CAS_MIN);
  localparam logic [CNT_W-1:0] RAS_MIN = CNT_W'(RMW_RAS_MIN);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             early;
  logic             rmw_ok;
  logic             indet;
  logic             oe_seen;
  logic [1:0]       wr;
  logic [CNT_W-1:0] cas_cnt;
  logic             late_ok;

  assign late_ok = (cas_cnt >= CAS_MIN) && (ras_cnt >= RAS_MIN);

  always_ff @(posedge clk) begin
    if (rst) begin
      act     <= 1'b0;
      early   <= 1'b0;
      rmw_ok  <= 1'b0;
      indet   <= 1'b0;
      oe_seen <= 1'b0;
      wr      <= 2'b00;
      cas_cnt <= '0;
    end else if (start) begin
      act     <= 1'b1;
      early   <= |(~we_n);
      wr      <= ~we_n;
      rmw_ok  <= 1'b0;
      indet   <= 1'b0;
      oe_seen <= ~oe_n;
      cas_cnt <= CNT_W'(1);
    end else if (finish) begin
      act <= 1'b0;
    end else if (act) begin
      if (cas_cnt != CNT_MAX) cas_cnt <= cas_cnt + CNT_W'(1);
      if (!oe_n) oe_seen <= 1'b1;
      if (|we_fall) begin
        wr <= wr | we_fall;
        if (!early) begin
          if (late_ok) rmw_ok <= 1'b1;
          else         indet  <= 1'b1;
        end
      end
    end
  end

  wmode_e           wm;
  logic [1:0][1:0]  lane_code;

  assign wm = early ? WM_EARLY : (rmw_ok ? WM_RMW : WM_NONE);

  for (genvar g = 0; g < 2; g++) begin : g_lane
    assign lane_code[g] = wr[g] ? ((wm == WM_RMW) ? LANE_OUT_IN : LANE_IN)
                                : ((oe_seen && !early) ? LANE_OUT : LANE_HIZ);
  end

  always_comb begin
    unique case (wr)
      2'b00:   info.cls = CLS_READ;
      2'b01:   info.cls = CLS_WR_LO;
      2'b10:   info.cls = CLS_WR_HI;
      default: info.cls = CLS_WR_WORD;
    endcase
    info.wm  = wm;
    info.err = indet;
    info.lo  = lane_code[0];
    info.hi  = lane_code[1];
  end

  // R5: the column delay counter never moves backwards inside an access
  p_cnt_rises_r5: assert property (@(posedge clk) disable iff (rst)
    (act && !start && !finish) |=> (cas_cnt >= $past(cas_cnt)));

  // R6: the error flag only appears after a late write strobe fall
  p_indet_cause_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(indet) |-> $past(act && (|we_fall) && !early));

  // R8: a new column access never starts over an open one
  p_one_access_r8: assert property (@(posedge clk) disable iff (rst)
    start |-> !act);

endmodule

// File: rtl/dram_cycle_monitor.sv
module dram_cycle_monitor
  import dcm_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int CNT_W       = 6,
  parameter int RMW_CAS_MIN = 4,
  parameter int RMW_RAS_MIN = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              lwe_n,
  input  logic              uwe_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              rpt_valid,
  output logic [2:0]        rpt_class,
  output logic [1:0]        rpt_wmode,
  output logic              rpt_err,
  output logic [1:0]        rpt_lane_lo,
  output logic [1:0]        rpt_lane_hi,
  output logic [ADDR_W-1:0] rpt_row,
  output logic [ADDR_W-1:0] rpt_col
);

  localparam int                PIN_W    = 5 + ADDR_W;
  localparam logic [PIN_W-1:0]  PIN_IDLE = {5'b11111, {ADDR_W{1'b0}}};
  localparam logic [CNT_W-1:0]  CNT_MAX  = '1;

  logic [PIN_W-1:0] pins_s;

  dcm_sync #(
    .W       (PIN_W),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (PIN_IDLE)
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({ras_n, cas_n, uwe_n, lwe_n, oe_n, addr}),
    .q   (pins_s)
  );

  logic              s_ras, s_cas, s_oe;
  logic [1:0]        s_we;
  logic [ADDR_W-1:0] s_addr;

  assign s_ras  = pins_s[PIN_W-1];
  assign s_cas  = pins_s[PIN_W-2];
  assign s_we   = pins_s[PIN_W-3 -: 2];
  assign s_oe   = pins_s[ADDR_W];
  assign s_addr = pins_s[ADDR_W-1:0];

  logic       p_ras, p_cas;
  logic [1:0] p_we;

  always_ff @(posedge clk) begin
    if (rst) begin
      p_ras <= 1'b1;
      p_cas <= 1'b1;
      p_we  <= 2'b11;
    end else begin
      p_ras <= s_ras;
      p_cas <= s_cas;
      p_we  <= s_we;
    end
  end

  logic       ras_fall, ras_rise, cas_fall, cas_rise;
  logic [1:0] we_fall;

  assign ras_fall = p_ras & ~s_ras;
  assign ras_rise = ~p_ras & s_ras;
  assign cas_fall = p_cas & ~s_cas;
  assign cas_rise = ~p_cas & s_cas;
  assign we_fall  = p_we & ~s_we;

  logic              cbr;
  logic              col_seen;
  logic [ADDR_W-1:0] row_q, col_q;
  logic [CNT_W-1:0]  ras_cnt;
  logic              acc_act, acc_start, acc_finish;
  acc_info_t         acc_info;

  assign acc_start  = cas_fall & ~s_ras & ~cbr;
  assign acc_finish = acc_act & (cas_rise | ras_rise);

  dcm_access #(
    .CNT_W       (CNT_W),
    .RMW_CAS_MIN (RMW_CAS_MIN),
    .RMW_RAS_MIN (RMW_RAS_MIN)
  ) u_acc (
    .clk     (clk),
    .rst     (rst),
    .start   (acc_start),
    .finish  (acc_finish),
    .we_n    (s_we),
    .we_fall (we_fall),
    .oe_n    (s_oe),
    .ras_cnt (ras_cnt),
    .act     (acc_act),
    .info    (acc_info)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cbr      <= 1'b0;
      col_seen <= 1'b0;
      row_q    <= '0;
      col_q    <= '0;
      ras_cnt  <= '0;
    end else begin
      if (ras_fall) begin
        row_q    <= s_addr;
        cbr      <= ~s_cas & ~p_cas;
        col_seen <= 1'b0;
        ras_cnt  <= CNT_W'(1);
      end else if (!s_ras && ras_cnt != CNT_MAX) begin
        ras_cnt <= ras_cnt + CNT_W'(1);
      end
      if (ras_rise) cbr <= 1'b0;
      if (acc_start) begin
        col_q    <= s_addr;
        col_seen <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rpt_valid   <= 1'b0;
      rpt_class   <= CLS_STANDBY;
      rpt_wmode   <= WM_NONE;
      rpt_err     <= 1'b0;
      rpt_lane_lo <= LANE_HIZ;
      rpt_lane_hi <= LANE_HIZ;
      rpt_row     <= '0;
      rpt_col     <= '0;
    end else begin
      rpt_valid   <= 1'b0;
      rpt_class   <= CLS_STANDBY;
      rpt_wmode   <= WM_NONE;
      rpt_err     <= 1'b0;
      rpt_lane_lo <= LANE_HIZ;
      rpt_lane_hi <= LANE_HIZ;
      rpt_row     <= '0;
      rpt_col     <= '0;
      if (acc_finish) begin
        rpt_valid   <= 1'b1;
        rpt_class   <= acc_info.cls;
        rpt_wmode   <= acc_info.wm;
        rpt_err     <= acc_info.err;
        rpt_lane_lo <= acc_info.lo;
        rpt_lane_hi <= acc_info.hi;
        rpt_row     <= row_q;
        rpt_col     <= col_q;
      end else if (ras_rise && cbr) begin
        rpt_valid <= 1'b1;
        rpt_class <= CLS_REF_CBR;
      end else if (ras_rise && !col_seen) begin
        rpt_valid <= 1'b1;
        rpt_class <= CLS_REF_ROW;
        rpt_row   <= row_q;
      end
    end
  end

  // R2: each report lasts a single cycle
  p_single_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    rpt_valid |=> !rpt_valid);

  // R9, R10: refresh reports carry no data movement
  p_refresh_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    (rpt_valid && (rpt_class == CLS_REF_ROW || rpt_class == CLS_REF_CBR))
      |-> (rpt_lane_lo == LANE_HIZ && rpt_lane_hi == LANE_HIZ && rpt_wmode == WM_NONE));

  // R3: reads carry no write mode and no error
  p_read_clean_r3: assert property (@(posedge clk) disable iff (rst)
    (rpt_valid && rpt_class == CLS_READ) |-> (rpt_wmode == WM_NONE && !rpt_err));

  // R6: the error flag never accompanies an early write
  p_err_not_early_r6: assert property (@(posedge clk) disable iff (rst)
    (rpt_valid && rpt_err) |-> (rpt_wmode != WM_EARLY));

  // R10: no column access runs inside a column-first refresh period
  p_cbr_no_access_r10: assert property (@(posedge clk) disable iff (rst)
    cbr |-> !acc_act);

endmodule

// File: tb/dram_cycle_monitor_bench.sv
`timescale 1ns/1ps
module dram_cycle_monitor_bench;

  logic       clk = 1'b0;
  logic       rst;
  logic       ras, cas, lwe, uwe, oe;
  logic [7:0] addr;

  logic       rpt_valid, rpt_err;
  logic [2:0] rpt_class;
  logic [1:0] rpt_wmode, rpt_lane_lo, rpt_lane_hi;
  logic [7:0] rpt_row, rpt_col;

  always #5 clk = ~clk;

  dram_cycle_monitor u_dram_cycle_monitor (
    .clk(clk), .rst(rst), .ras_n(ras), .cas_n(cas), .lwe_n(lwe), .uwe_n(uwe),
    .oe_n(oe), .addr(addr), .rpt_valid(rpt_valid), .rpt_class(rpt_class),
    .rpt_wmode(rpt_wmode), .rpt_err(rpt_err), .rpt_lane_lo(rpt_lane_lo),
    .rpt_lane_hi(rpt_lane_hi), .rpt_row(rpt_row), .rpt_col(rpt_col)
  );

  int n_chk = 0;
  int n_bad = 0;
  int rc_n  = 0;
  bit done  = 1'b0;
  logic [25:0] rc_w [256];

  function automatic logic [25:0] out_word();
    return {rpt_class, rpt_wmode, rpt_err, rpt_lane_lo, rpt_lane_hi, rpt_row, rpt_col};
  endfunction

  function automatic logic [25:0] mk(input logic [2:0] c, input logic [1:0] w, input logic e,
                                     input logic [1:0] lo, input logic [1:0] hi,
                                     input logic [7:0] r, input logic [7:0] cl);
    return {c, w, e, lo, hi, r, cl};
  endfunction

  always @(negedge clk) begin
    if (!rst && rpt_valid) begin
      rc_w[rc_n % 256] = out_word();
      rc_n = rc_n + 1;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic logic [25:0] exp_acc(input logic [1:0] e, input logic [1:0] l,
                                          input int r, input int k, input logic oe_low,
                                          input logic [7:0] row, input logic [7:0] col);
    logic [1:0] w;
    logic       ok;
    logic [2:0] c;
    logic [1:0] wm;
    logic       er;
    logic [1:0] ln [2];
    w  = e | l;
    ok = (k >= 4) && (r + k >= 8);
    c  = (w == 2'd0) ? 3'd1 : (w == 2'd1) ? 3'd2 : (w == 2'd2) ? 3'd3 : 3'd4;
    wm = (e != 0) ? 2'd1 : ((l != 0 && ok) ? 2'd2 : 2'd0);
    er = (e == 0) && (l != 0) && !ok;
    for (int i = 0; i < 2; i++)
      ln[i] = w[i] ? ((wm == 2'd2) ? 2'd3 : 2'd2) : ((oe_low && e == 0) ? 2'd1 : 2'd0);
    return mk(c, wm, er, ln[0], ln[1], row, col);
  endfunction

  task automatic run_access(input logic [7:0] row, input logic [7:0] col, input int r,
                            input int k, input logic [1:0] e, input logic [1:0] l,
                            input logic oe_low, input string tag);
    int base;
    base = rc_n;
    addr = row; tick(1);
    ras = 1'b0; tick(r);
    addr = col; cas = 1'b0; lwe = ~e[0]; uwe = ~e[1]; oe = ~oe_low;
    if (l != 0) begin
      tick(k);
      if (l[0]) lwe = 1'b0;
      if (l[1]) uwe = 1'b0;
      tick(2);
    end else begin
      tick(3);
    end
    cas = 1'b1; tick(1);
    ras = 1'b1; lwe = 1'b1; uwe = 1'b1; oe = 1'b1; tick(5);
    chk(rc_n, base + 1, {tag, " report count"});
    chk(rc_w[base % 256], exp_acc(e, l, r, k, oe_low, row, col), tag);
    chk(rc_w[base % 256][15:0], {row, col}, "R7 row/col latch");
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R12 watchdog got=hung exp=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int base;
    int lat;
    rst = 1'b1; ras = 1'b1; cas = 1'b1; lwe = 1'b1; uwe = 1'b1; oe = 1'b1; addr = 8'h00;
    tick(4);
    chk({31'd0, rpt_valid}, 32'd0, "R1 valid in reset");
    chk(out_word(), 26'd0, "R1 fields in reset");
    rst = 1'b0; tick(1);
    chk({out_word(), rpt_valid}, 27'd0, "R1 after release");

    // R2 latency
    base = rc_n;
    addr = 8'h33; tick(1); ras = 1'b0; tick(2);
    addr = 8'h44; cas = 1'b0; oe = 1'b0; tick(3);
    cas = 1'b1; lat = 0;
    for (int i = 1; i <= 6; i++) begin
      @(negedge clk); #1;
      if (rpt_valid && lat == 0) lat = i;
    end
    chk(lat, 3, "R2 latency");
    ras = 1'b1; oe = 1'b1; tick(5);
    chk(rc_n, base + 1, "R2 one report");

    // R3 reads and R4 early writes, both output-enable settings
    for (int o = 0; o < 2; o++)
      for (int e = 0; e < 4; e++)
        run_access(8'h10 + 8'(e), 8'hA0 + 8'(o * 4 + e), 2, 0, 2'(e), 2'b00, 1'(o),
                   (e == 0) ? "R3 read" : "R4 early write");

    // R5 / R6 sweep of late write strobe timing
    for (int l = 1; l < 4; l++)
      for (int ri = 0; ri < 3; ri++)
        for (int k = 1; k <= 6; k++) begin
          int r;
          logic ok;
          r  = 1 + 2 * ri;
          ok = (k >= 4) && (r + k >= 8);
          run_access(8'h40 + 8'(l * 16 + ri), 8'h80 + 8'(k), r, k, 2'b00, 2'(l), 1'(k % 2),
                     ok ? "R5 read-modify-write" : "R6 indeterminate");
        end

    // R8 page mode
    base = rc_n;
    addr = 8'h5A; tick(1); ras = 1'b0; tick(2);
    for (int p = 0; p < 3; p++) begin
      addr = 8'hC0 + 8'(p); cas = 1'b0;
      if (p < 2) oe = 1'b0; else lwe = 1'b0;
      tick(2);
      cas = 1'b1; lwe = 1'b1; oe = 1'b1; tick(2);
    end
    ras = 1'b1; tick(5);
    chk(rc_n, base + 3, "R8 page report count");
    chk(rc_w[base % 256], mk(3'd1, 2'd0, 1'b0, 2'd1, 2'd1, 8'h5A, 8'hC0), "R8 page first");
    chk(rc_w[(base + 1) % 256], mk(3'd1, 2'd0, 1'b0, 2'd1, 2'd1, 8'h5A, 8'hC1), "R8 page second");
    chk(rc_w[(base + 2) % 256], mk(3'd2, 2'd1, 1'b0, 2'd2, 2'd0, 8'h5A, 8'hC2), "R8 page third");

    // R9 row-only refresh
    base = rc_n;
    addr = 8'h77; tick(1); ras = 1'b0; tick(5); ras = 1'b1; tick(5);
    chk(rc_n, base + 1, "R9 count");
    chk(rc_w[base % 256], mk(3'd5, 2'd0, 1'b0, 2'd0, 2'd0, 8'h77, 8'h00), "R9 row refresh");

    // R10 column-first refresh with an ignored column pulse
    base = rc_n;
    addr = 8'h99; cas = 1'b0; tick(2); ras = 1'b0; tick(3);
    cas = 1'b1; tick(1); cas = 1'b0; tick(2);
    ras = 1'b1; tick(2); cas = 1'b1; tick(5);
    chk(rc_n, base + 1, "R10 count");
    chk(rc_w[base % 256], mk(3'd6, 2'd0, 1'b0, 2'd0, 2'd0, 8'h00, 8'h00), "R10 cbr refresh");

    // R12 column pulse in standby
    base = rc_n;
    cas = 1'b0; tick(3); cas = 1'b1; tick(5);
    chk(rc_n, base, "R12 standby pulse ignored");
    chk({out_word(), rpt_valid}, 27'd0, "R12 idle outputs");

    // R11 both strobes rise in the same sample
    base = rc_n;
    addr = 8'h21; tick(1); ras = 1'b0; tick(2);
    addr = 8'h42; cas = 1'b0; oe = 1'b0; tick(3);
    cas = 1'b1; ras = 1'b1; oe = 1'b1; tick(5);
    chk(rc_n, base + 1, "R11 simultaneous rise count");
    chk(rc_w[base % 256], mk(3'd1, 2'd0, 1'b0, 2'd1, 2'd1, 8'h21, 8'h42), "R11 simultaneous");

    // R11 + R10 hidden refresh: column strobe held across the row rise
    base = rc_n;
    addr = 8'h31; tick(1); ras = 1'b0; tick(2);
    addr = 8'h62; cas = 1'b0; oe = 1'b0; tick(3);
    ras = 1'b1; tick(2); oe = 1'b1;
    ras = 1'b0; tick(3); ras = 1'b1; tick(2); cas = 1'b1; tick(5);
    chk(rc_n, base + 2, "R11 hidden count");
    chk(rc_w[base % 256], mk(3'd1, 2'd0, 1'b0, 2'd1, 2'd1, 8'h31, 8'h62), "R11 hidden access");
    chk(rc_w[(base + 1) % 256], mk(3'd6, 2'd0, 1'b0, 2'd0, 2'd0, 8'h00, 8'h00), "R10 hidden cbr");

    done = 1'b1;
    summary();
    $finish;
  end

endmodule